// File: doc/BRIEF.md
# Capture Edge Detector with History Flush

This block is the input stage of one capture channel in a general-purpose timer. An asynchronous signal is brought into the timer clock domain through a synchroniser chain. The synchronised level is then compared with a stored copy of the previous sampled level, and a one-cycle strobe is raised for every rising or falling transition. The capture logic downstream uses these strobes to latch the counter.

The detector works only while the channel is configured for capture and the timer mode is not the disabled code. When it is not working, the stored level stays frozen. If the timer moves from disabled to any running mode while capture is selected, the stored history is flushed over a fixed number of timer clock periods (two by default). During that window the history reloads from the live synchronised level and no strobe can be raised. As a result, a level that changed while the timer was stopped cannot produce a false capture when the timer starts again.

Top module: `cap_edge_flush`

## Requirements
- R1: After reset, `rise_stb` and `fall_stb` are low. The stored level is 0, and the remembered previous mode is the disabled code.
- R2: A strobe is produced only in the cycle after a clock edge where `cap_sel` is 1 and `tmr_mode` is not 0. Mode code 0 means disabled, and codes 1 to 3 mean running. Input changes at any other time produce no strobe.
- R3: With the detector active and no flush in progress, a 0-to-1 change of `sig_async` raises `rise_stb` for exactly one cycle. The input must be driven before clock edge 1 and then held. The strobe goes high at edge SYNC_STAGES+1 (edge 3 by default) and falls at the following edge.
- R4: A 1-to-0 change behaves the same way on `fall_stb`. The two strobes are never high together.
- R5: A flush starts at a clock edge where `cap_sel` is 1, `tmr_mode` is not 0, and the mode sampled at the previous edge was 0. The flush covers that edge and the next FLUSH_CYCLES-1 edges. No strobe follows any flush edge.
- R6: During a flush the stored level reloads from the synchronised input. A level that changed while the timer was disabled produces no strobe after the flush. The same holds for a level that reaches the detector during the flush.
- R7: The flush lasts exactly FLUSH_CYCLES edges. An input changed together with the mode change reaches the detector at the first edge after the flush, and it is reported there as a normal edge.
- R8: A change from one running mode code to another does not start a flush.
- R9: While `cap_sel` is 0 the stored level is frozen. If capture is selected again while the mode is running, no flush starts. The frozen level is compared with the live level, so an input change made in the meantime is reported at the first active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_async | input | 1 | Signal to be captured, not synchronised to `clk` |
| cap_sel | input | 1 | Channel is configured for a capture function |
| tmr_mode | input | 2 | Timer mode: 0 means disabled, any other code means running |
| rise_stb | output | 1 | One-cycle strobe for a rising edge |
| fall_stb | output | 1 | One-cycle strobe for a falling edge |

## Verification
The assertions assume that `cap_sel` and `tmr_mode` are static between clock edges. They also assume that a flush begins only from a mode that was really sampled as disabled, so the mode history used by the checker is trusted only from the second edge after reset. The bench drives every input on the falling clock edge. It holds each input level for at least three cycles, unless a test places a change relative to a mode switch on purpose, as the flush-window cases do. In this way every synchroniser stage sees a clean level.

// File: rtl/cap_edge_pkg.sv
package cap_edge_pkg;

  localparam int MODE_W = 2;

  typedef logic [MODE_W-1:0] tmr_mode_t;

  localparam tmr_mode_t MODE_OFF = '0;

  function automatic logic mode_running(tmr_mode_t m);
    return m != MODE_OFF;
  endfunction

  function automatic logic rise_of(logic prev, logic cur);
    return cur & ~prev;
  endfunction

  function automatic logic fall_of(logic prev, logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_flush_ctl.sv
module cap_flush_ctl
  import cap_edge_pkg::*;
#(
  parameter int FLUSH_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_sel,
  input  tmr_mode_t tmr_mode,
  output logic      active,
  output logic      flush_start,
  output logic      flushing
);
  localparam int CW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;

  tmr_mode_t     mode_q;
  logic [CW-1:0] left_q;

  assign active      = cap_sel & mode_running(tmr_mode);
  assign flush_start = active & ~mode_running(mode_q);
  assign flushing    = flush_start | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      left_q <= '0;
    end else begin
      mode_q <= tmr_mode;
      if (!active)          left_q <= '0;
      else if (flush_start) left_q <= CW'(FLUSH_CYCLES - 1);
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cap_edge_core.sv
module cap_edge_core
  import cap_edge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic flushing,
  input  logic lvl,
  output logic rise_stb,
  output logic fall_stb
);
  logic hist_q;
  logic detect_en;

  assign detect_en = active & ~flushing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      if (active) hist_q <= lvl;
      rise_stb <= detect_en & rise_of(hist_q, lvl);
      fall_stb <= detect_en & fall_of(hist_q, lvl);
    end
  end
endmodule

// File: rtl/cap_edge_flush.sv
module cap_edge_flush
  import cap_edge_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FLUSH_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_async,
  input  logic              cap_sel,
  input  logic [MODE_W-1:0] tmr_mode,
  output logic              rise_stb,
  output logic              fall_stb
);
  logic sync_lvl;
  logic active;
  logic flush_start;
  logic flushing;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (sig_async),
    .q   (sync_lvl)
  );

  cap_flush_ctl #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_sel     (cap_sel),
    .tmr_mode    (tmr_mode),
    .active      (active),
    .flush_start (flush_start),
    .flushing    (flushing)
  );

  cap_edge_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .flushing (flushing),
    .lvl      (sync_lvl),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );
endmodule

// File: rtl/cap_edge_flush_chk.sv
module cap_edge_flush_chk
  import cap_edge_pkg::*;
#(
  parameter int FLUSH_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_sel,
  input logic [MODE_W-1:0] tmr_mode,
  input logic              sync_lvl,
  input logic              active,
  input logic              flush_start,
  input logic              flushing,
  input logic              rise_stb,
  input logic              fall_stb
);
  localparam int RW = $clog2(FLUSH_CYCLES + 2);

  logic          past_ok;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      run_len <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!flushing)                      run_len <= '0;
      else if (run_len != RW'(FLUSH_CYCLES)) run_len <= run_len + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !rise_stb && !fall_stb); // R1
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_sel && tmr_mode != MODE_OFF) |=> !rise_stb && !fall_stb); // R2
  AST_RISE_SEES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rise_stb |-> $past(sync_lvl)); // R3
  AST_FALL_SEES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && fall_stb |-> !$past(sync_lvl)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R4
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb); // R3
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> !rise_stb && !fall_stb); // R5
  AST_FLUSH_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> run_len < RW'(FLUSH_CYCLES)); // R7
  AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (FLUSH_CYCLES > 1) && flush_start ##1 active |-> flushing); // R5
  AST_RUN_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(tmr_mode) != MODE_OFF |-> !flush_start); // R8
endmodule

bind cap_edge_flush cap_edge_flush_chk #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_sel     (cap_sel),
  .tmr_mode    (tmr_mode),
  .sync_lvl    (sync_lvl),
  .active      (active),
  .flush_start (flush_start),
  .flushing    (flushing),
  .rise_stb    (rise_stb),
  .fall_stb    (fall_stb)
);

// File: tb/cap_edge_flush_test.sv
module cap_edge_flush_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_async = 1'b0;
  logic       cap_sel = 1'b0;
  logic [1:0] tmr_mode = 2'd0;
  logic       rise_stb;
  logic       fall_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cap_edge_flush uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_async (sig_async),
    .cap_sel   (cap_sel),
    .tmr_mode  (tmr_mode),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_strobes(input int n, output int rc, output int fc);
    rc = 0; fc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rc += int'(rise_stb);
      fc += int'(fall_stb);
    end
  endtask

  task automatic settle(input logic lvl, input logic [1:0] m);
    cap_sel = 1'b1; tmr_mode = m; sig_async = lvl;
    step(8);
  endtask

  task automatic t_reset;
    check("R1 rise after reset", int'(rise_stb), 0);
    check("R1 fall after reset", int'(fall_stb), 0);
  endtask

  task automatic t_rise;
    settle(1'b0, 2'd1);
    sig_async = 1'b1;
    step(2); check("R3 rise not early", int'(rise_stb), 0);
    step(1); check("R3 rise at edge 3", int'(rise_stb), 1);
    check("R4 no fall with rise", int'(fall_stb), 0);
    step(1); check("R3 rise one cycle", int'(rise_stb), 0);
  endtask

  task automatic t_fall;
    settle(1'b1, 2'd3);
    sig_async = 1'b0;
    step(2); check("R4 fall not early", int'(fall_stb), 0);
    step(1); check("R4 fall at edge 3", int'(fall_stb), 1);
    check("R4 no rise with fall", int'(rise_stb), 0);
    step(1); check("R4 fall one cycle", int'(fall_stb), 0);
  endtask

  task automatic t_ignore;
    int rc, fc;
    settle(1'b0, 2'd1);
    tmr_mode = 2'd0;
    sig_async = 1'b1; step(4); sig_async = 1'b0;
    count_strobes(5, rc, fc);
    check("R2 mode 0 rises", rc, 0);
    check("R2 mode 0 falls", fc, 0);
  endtask

  task automatic t_flush_stale;
    int rc, fc;
    settle(1'b0, 2'd1);
    tmr_mode = 2'd0; step(1);
    sig_async = 1'b1; step(6);
    tmr_mode = 2'd2;
    count_strobes(8, rc, fc);
    check("R6 stale level no rise", rc, 0);
    check("R6 stale level no fall", fc, 0);
  endtask

  task automatic t_flush_inside;
    int rc, fc;
    settle(1'b0, 2'd1);
    tmr_mode = 2'd0; step(4);
    sig_async = 1'b1; step(1);
    tmr_mode = 2'd1;
    count_strobes(8, rc, fc);
    check("R5 change inside flush no rise", rc, 0);
  endtask

  task automatic t_flush_len;
    settle(1'b1, 2'd1);
    tmr_mode = 2'd0; step(4);
    sig_async = 1'b0; tmr_mode = 2'd1;
    step(2); check("R7 no fall during flush", int'(fall_stb), 0);
    step(1); check("R7 fall right after flush", int'(fall_stb), 1);
  endtask

  task automatic t_run_to_run;
    settle(1'b0, 2'd1);
    sig_async = 1'b1; step(1);
    tmr_mode = 2'd2;
    step(2); check("R8 no flush between run codes", int'(rise_stb), 1);
  endtask

  task automatic t_frozen;
    int rc, fc;
    settle(1'b0, 2'd1);
    cap_sel = 1'b0; sig_async = 1'b1;
    count_strobes(6, rc, fc);
    check("R2 capture off no rise", rc, 0);
    cap_sel = 1'b1;
    step(1); check("R9 frozen level compared", int'(rise_stb), 1);
    step(1); check("R9 single strobe", int'(rise_stb), 0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_rise();
    t_fall();
    t_ignore();
    t_flush_stale();
    t_flush_inside();
    t_flush_len();
    t_run_to_run();
    t_frozen();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule